// File: doc/BRIEF.md
# Trailing-Thread Branch Replay Queue with Fetch Slack Gate

In a processor that runs two redundant copies of one program, the leading copy retires branches first. Each time it retires one, it records the branch address, whether the branch was taken, and the target address in this queue. The trailing copy fetches later. When it reaches a branch, it presents the fetch address to the queue. If the address matches the oldest entry, that entry gives the trailing copy a correct direction and target. The entry then leaves the queue. The trailing copy therefore never mispredicts, and both copies follow the same path.

Alongside the queue, a slack gate compares the fetched-instruction counts of the two copies. It enables trailing fetch only when the leading copy is at least a set number of instructions ahead. This gives the leading copy time to resolve branches and to warm the caches before the trailing copy needs them.

If the trailing copy reaches a branch while the queue is empty, the lookup reports a stall. If its address disagrees with the oldest entry, the two copies have diverged, and a sticky error flag is raised. A full queue holds off the leading copy's branch retirement.

Top module: `brq_top`

## Requirements
- R1: After reset the queue is empty, `lead_push_ready` is 1 and `diverge_err` is 0.
- R2: Entries leave the queue in the order they were pushed, each returning its own taken flag and target.
- R3: With DEPTH entries held, `lead_push_ready` is 0, and a push offered in that state is discarded without changing the stored entries.
- R4: When `trail_br_valid` is 1 and `trail_br_pc` equals the oldest entry's address, `trail_hit` is 1 in the same cycle, `trail_taken`/`trail_target` carry that entry's outcome, and the entry is removed at the next clock edge.
- R5: When `trail_br_valid` is 1 and the queue is empty, `trail_stall` is 1, `trail_hit` is 0, and nothing is removed.
- R6: When `trail_br_valid` is 1, the queue is non-empty and `trail_br_pc` differs from the oldest entry's address, `trail_hit` is 0, no entry is removed, and `diverge_err` becomes 1 from the next clock edge and stays 1 until reset.
- R7: With gap = (`lead_count` - `trail_count`) mod 2^CNT_W, `trail_fetch_en` is 1 exactly when gap >= SLACK and the top bit of gap is 0, which means a trailing copy ahead of the leading one is never enabled.
- R8: A push and a pop in the same cycle leave the occupancy unchanged, and the pushed entry becomes the new oldest once the popped one is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_push_valid | input | 1 | Leading copy retires a branch this cycle |
| lead_push_pc | input | PC_W | Retired branch address |
| lead_push_taken | input | 1 | Retired branch direction, 1 = taken |
| lead_push_target | input | PC_W | Retired branch target address |
| lead_push_ready | output | 1 | Queue can accept a branch (0 stalls retirement) |
| trail_br_valid | input | 1 | Trailing copy is fetching a branch |
| trail_br_pc | input | PC_W | Trailing branch fetch address |
| trail_hit | output | 1 | Oldest entry matches; outcome valid, entry consumed |
| trail_taken | output | 1 | Direction from the oldest entry |
| trail_target | output | PC_W | Target from the oldest entry |
| trail_stall | output | 1 | Queue empty at a trailing branch |
| diverge_err | output | 1 | Sticky address-mismatch flag |
| lead_count | input | CNT_W | Leading copy fetched-instruction count |
| trail_count | input | CNT_W | Trailing copy fetched-instruction count |
| trail_fetch_en | output | 1 | Trailing fetch permitted by the slack rule |

## Verification
On every cycle, the assertions check several invariants. Occupancy never exceeds DEPTH and stays frozen while full and unread. A hit always removes exactly one entry, and a stall only ever appears with an empty queue. Hit and stall never occur together, the divergence flag never drops once set, and equal counts never enable trailing fetch. Only the directed scenarios can show that values come out in push order with the right direction and target, and that a push refused while full is truly lost. They also show that a mismatched lookup leaves the head in place, and that the slack threshold sits at exactly SLACK, including across counter wrap.

// File: rtl/brq_pkg.sv
package brq_pkg;

   // Outcome of a trailing-thread branch lookup against the queue head
   typedef enum logic [1:0] {
      LK_IDLE    = 2'd0,
      LK_HIT     = 2'd1,
      LK_STALL   = 2'd2,
      LK_DIVERGE = 2'd3
   } lookup_e;

endpackage

// File: rtl/brq_store.sv
module brq_store #(
   parameter int DEPTH = 128,
   parameter int DW    = 65,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   if (DEPTH < 2) begin : g_depth_chk
      $error("brq_store: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wptr, rptr, wnext, rnext;

   // Pointer advance: natural wrap for power-of-two depth, explicit otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wnext = wptr + 1'b1;
      assign rnext = rptr + 1'b1;
   end else begin : g_wrap
      assign wnext = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rnext = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr_en) wptr <= wnext;
         if (rd_en) rptr <= rnext;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rd_data = mem[rptr];
   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);

endmodule

// File: rtl/brq_head_match.sv
module brq_head_match
   import brq_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            req_valid,
   input  logic [PC_W-1:0] req_pc,
   input  logic            q_empty,
   input  logic [PC_W-1:0] head_pc,
   output lookup_e         result
);

   always_comb begin
      if (!req_valid)          result = LK_IDLE;
      else if (q_empty)        result = LK_STALL;
      else if (req_pc == head_pc) result = LK_HIT;
      else                     result = LK_DIVERGE;
   end

endmodule

// File: rtl/brq_slack_gate.sv
module brq_slack_gate #(
   parameter int CNT_W = 32,
   parameter int SLACK = 256
) (
   input  logic [CNT_W-1:0] lead_count,
   input  logic [CNT_W-1:0] trail_count,
   output logic             fetch_en
);

   if (CNT_W < 2 || CNT_W > 63) begin : g_width_chk
      $error("brq_slack_gate: CNT_W out of range");
   end
   if (SLACK < 1 || longint'(SLACK) >= (64'd1 << (CNT_W - 1))) begin : g_slack_chk
      $error("brq_slack_gate: SLACK must be positive and below half the counter range");
   end

   logic [CNT_W-1:0] gap;
   logic             at_least;

   assign gap = lead_count - trail_count;

   // Power-of-two slack reduces to an OR of the upper gap bits
   if ((SLACK & (SLACK - 1)) == 0) begin : g_pow2
      localparam int LG = $clog2(SLACK);
      if (LG == 0) begin : g_one
         assign at_least = |gap;
      end else begin : g_bits
         assign at_least = |gap[CNT_W-1:LG];
      end
   end else begin : g_cmp
      assign at_least = (gap >= CNT_W'(SLACK));
   end

   // Top bit set means trailing is ahead of leading
   assign fetch_en = at_least && !gap[CNT_W-1];

endmodule

// File: rtl/brq_top.sv
module brq_top
   import brq_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int DEPTH = 128,
   parameter int SLACK = 256,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lead_push_valid,
   input  logic [PC_W-1:0]  lead_push_pc,
   input  logic             lead_push_taken,
   input  logic [PC_W-1:0]  lead_push_target,
   output logic             lead_push_ready,
   input  logic             trail_br_valid,
   input  logic [PC_W-1:0]  trail_br_pc,
   output logic             trail_hit,
   output logic             trail_taken,
   output logic [PC_W-1:0]  trail_target,
   output logic             trail_stall,
   output logic             diverge_err,
   input  logic [CNT_W-1:0] lead_count,
   input  logic [CNT_W-1:0] trail_count,
   output logic             trail_fetch_en
);

   localparam int DW = 1 + 2 * PC_W;
   localparam int CW = $clog2(DEPTH + 1);

   if (PC_W < 1) begin : g_pc_chk
      $error("brq_top: PC_W must be positive");
   end

   logic [DW-1:0] wr_word, head_word;
   logic [CW-1:0] occ;
   logic          q_full, q_empty, wr_en, rd_en;
   logic [PC_W-1:0] head_pc;
   lookup_e       lk;

   assign lead_push_ready = !q_full;
   assign wr_en   = lead_push_valid && !q_full;
   assign wr_word = {lead_push_taken, lead_push_target, lead_push_pc};

   brq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_word),
      .rd_en   (rd_en),
      .rd_data (head_word),
      .count   (occ),
      .full    (q_full),
      .empty   (q_empty)
   );

   assign head_pc      = head_word[PC_W-1:0];
   assign trail_target = head_word[2*PC_W-1:PC_W];
   assign trail_taken  = head_word[DW-1];

   brq_head_match #(.PC_W(PC_W)) u_match (
      .req_valid (trail_br_valid),
      .req_pc    (trail_br_pc),
      .q_empty   (q_empty),
      .head_pc   (head_pc),
      .result    (lk)
   );

   assign trail_hit   = (lk == LK_HIT);
   assign trail_stall = (lk == LK_STALL);
   assign rd_en       = trail_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)                 diverge_err <= 1'b0;
      else if (lk == LK_DIVERGE)  diverge_err <= 1'b1;
   end

   brq_slack_gate #(.CNT_W(CNT_W), .SLACK(SLACK)) u_slack (
      .lead_count  (lead_count),
      .trail_count (trail_count),
      .fetch_en    (trail_fetch_en)
   );

endmodule

// File: rtl/brq_checker.sv
module brq_checker #(
   parameter int DEPTH = 128,
   parameter int CNT_W = 32,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lead_push_valid,
   input logic             lead_push_ready,
   input logic             trail_hit,
   input logic             trail_stall,
   input logic             diverge_err,
   input logic [CNT_W-1:0] lead_count,
   input logic [CNT_W-1:0] trail_count,
   input logic             trail_fetch_en,
   input logic [CW-1:0]    occ
);

   assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   assert_full_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lead_push_ready && !trail_hit) |=> $stable(occ));

   assert_hit_pops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trail_hit && !(lead_push_valid && lead_push_ready)) |=> (occ == $past(occ) - CW'(1)));

   assert_both_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trail_hit && lead_push_valid && lead_push_ready) |=> $stable(occ));

   assert_stall_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      trail_stall |-> (occ == '0));

   assert_hit_stall_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(trail_hit && trail_stall));

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      diverge_err |=> diverge_err);

   assert_no_fetch_zero_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_count == trail_count) |-> !trail_fetch_en);

endmodule

bind brq_top brq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .lead_push_valid (lead_push_valid),
   .lead_push_ready (lead_push_ready),
   .trail_hit       (trail_hit),
   .trail_stall     (trail_stall),
   .diverge_err     (diverge_err),
   .lead_count      (lead_count),
   .trail_count     (trail_count),
   .trail_fetch_en  (trail_fetch_en),
   .occ             (occ)
);

// File: tb/tb_brq_top.sv
`timescale 1ns/1ps
module tb_brq_top;
   localparam int PC_W  = 32;
   localparam int DEPTH = 4;
   localparam int SLACK = 32;
   localparam int CNT_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lead_push_valid = 1'b0, lead_push_taken = 1'b0;
   logic [PC_W-1:0] lead_push_pc = '0, lead_push_target = '0;
   logic lead_push_ready;
   logic trail_br_valid = 1'b0;
   logic [PC_W-1:0] trail_br_pc = '0;
   logic trail_hit, trail_taken, trail_stall, diverge_err, trail_fetch_en;
   logic [PC_W-1:0] trail_target;
   logic [CNT_W-1:0] lead_count = '0, trail_count = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   brq_top #(.PC_W(PC_W), .DEPTH(DEPTH), .SLACK(SLACK), .CNT_W(CNT_W)) dut (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      lead_push_valid = 1'b0; trail_br_valid = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   // Offer one branch from the leading thread for one cycle
   task automatic push(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tg);
      lead_push_valid = 1'b1; lead_push_pc = pc; lead_push_taken = tk; lead_push_target = tg;
      @(negedge clk);
      lead_push_valid = 1'b0;
   endtask

   // Trailing lookup, checks outputs mid-cycle before the consuming edge
   task automatic lookup(input string req, input logic [PC_W-1:0] pc, input logic ex_hit,
                         input logic ex_stall, input logic ex_tk, input logic [PC_W-1:0] ex_tg);
      trail_br_valid = 1'b1; trail_br_pc = pc;
      #1;
      check(req, trail_hit, ex_hit);
      check(req, trail_stall, ex_stall);
      if (ex_hit) begin
         check(req, trail_taken, ex_tk);
         check(req, trail_target, ex_tg);
      end
      @(negedge clk);
      trail_br_valid = 1'b0;
   endtask

   task automatic t_reset();   // R1
      do_reset();
      #1;
      check("R1 ready", lead_push_ready, 1'b1);
      check("R1 err", diverge_err, 1'b0);
      @(negedge clk);
      lookup("R1 R5 empty stall", 32'h40, 1'b0, 1'b1, 1'b0, '0);
   endtask

   task automatic t_order();   // R2 R4
      push(32'h1000, 1'b1, 32'h2000);
      push(32'h1010, 1'b0, 32'h1014);
      push(32'h1020, 1'b1, 32'h0800);
      lookup("R2 R4 first", 32'h1000, 1'b1, 1'b0, 1'b1, 32'h2000);
      lookup("R2 second",   32'h1010, 1'b1, 1'b0, 1'b0, 32'h1014);
      lookup("R2 third",    32'h1020, 1'b1, 1'b0, 1'b1, 32'h0800);
      lookup("R4 R5 drained", 32'h1030, 1'b0, 1'b1, 1'b0, '0);
   endtask

   task automatic t_full();    // R3
      for (int i = 0; i < DEPTH; i++) push(32'h100 + i, i[0], 32'h900 + i);
      #1;
      check("R3 ready low when full", lead_push_ready, 1'b0);
      push(32'h1FF, 1'b1, 32'hDEAD);
      for (int i = 0; i < DEPTH; i++)
         lookup("R3 contents kept", 32'h100 + i, 1'b1, 1'b0, i[0], 32'h900 + i);
      lookup("R3 dropped push absent", 32'h1FF, 1'b0, 1'b1, 1'b0, '0);
      #1;
      check("R3 ready again", lead_push_ready, 1'b1);
   endtask

   task automatic t_simul();   // R8
      push(32'h3000, 1'b1, 32'h3100);
      lead_push_valid = 1'b1; lead_push_pc = 32'h3004; lead_push_taken = 1'b0; lead_push_target = 32'h3008;
      lookup("R8 pop while push", 32'h3000, 1'b1, 1'b0, 1'b1, 32'h3100);
      lead_push_valid = 1'b0;
      lookup("R8 pushed becomes head", 32'h3004, 1'b1, 1'b0, 1'b0, 32'h3008);
      lookup("R8 empty after", 32'h3004, 1'b0, 1'b1, 1'b0, '0);
   endtask

   task automatic t_slack();   // R7
      lead_count = 16'd100; trail_count = 16'd69; #1;
      check("R7 gap 31", trail_fetch_en, 1'b0);
      trail_count = 16'd68; #1;
      check("R7 gap 32", trail_fetch_en, 1'b1);
      lead_count = 16'd5; trail_count = 16'hFFFF - 16'd40; #1;
      check("R7 wrap gap 46", trail_fetch_en, 1'b1);
      lead_count = 16'd10; trail_count = 16'd20; #1;
      check("R7 trailing ahead", trail_fetch_en, 1'b0);
      lead_count = 16'd7; trail_count = 16'd7; #1;
      check("R7 equal", trail_fetch_en, 1'b0);
      @(negedge clk);
   endtask

   task automatic t_diverge(); // R6
      push(32'h5000, 1'b1, 32'h5500);
      lookup("R6 mismatch no hit", 32'h5004, 1'b0, 1'b0, 1'b0, '0);
      #1;
      check("R6 err set", diverge_err, 1'b1);
      @(negedge clk);
      lookup("R6 head not popped", 32'h5000, 1'b1, 1'b0, 1'b1, 32'h5500);
      #1;
      check("R6 err sticky", diverge_err, 1'b1);
      do_reset();
      #1;
      check("R1 R6 err cleared by reset", diverge_err, 1'b0);
   endtask

   initial begin
      t_reset();
      t_order();
      t_full();
      t_simul();
      t_slack();
      t_diverge();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule